// File: doc/BRIEF.md
# GPIO Interrupt Line Mux

This block maps the interrupt requests of three GPIO banks onto a smaller set of lines that feed a platform interrupt controller. The banks carry 14, 24 and 32 request sources, 70 in all, and the block drives 41 lines. Thirty-eight of these lines each give one source its own connection. Each of the last three lines collects, by OR, the sources of one bank that did not get their own line.

A 32-bit control word, held in a register and reached through a single-cycle write and read port, sets the routing. Each control bit governs a fixed pair of pins: a pin of bank 0 or bank 1 against a pin of bank 2. The bit grants the own line to one member of the pair and sends the other member to its bank's shared line. Six pins of bank 1 belong to no pair and always have their own lines. The request path from the sources to the lines has no register in it. Firmware normally loads the control word once, at boot.

Top module: `irq_line_mux`

## Requirements
- R1: The control register is all zeros while reset is asserted and after it is released, and `cfg_rdata` then reads 0.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the register at that clock edge, and `cfg_rdata` shows it from then on. A cycle with `cfg_we` low leaves the register unchanged.
- R3: For i from 0 to 13, `irq_out[i]` equals `src_b0[i]` when control bit i is 0 and `src_b2[i]` when it is 1.
- R4: For k from 0 to 17, `irq_out[14+k]` equals `src_b1[k]` when control bit 14+k is 0 and `src_b2[14+k]` when it is 1.
- R5: For m from 0 to 5, `irq_out[32+m]` equals `src_b1[18+m]` for every control value.
- R6: `irq_out[38]` is the OR of every `src_b0[i]` whose control bit i is 1, and is 0 when there is none.
- R7: `irq_out[39]` is the OR of every `src_b1[k]` whose control bit 14+k is 1, and is 0 when there is none.
- R8: `irq_out[40]` is the OR of every `src_b2[n]` whose control bit n is 0, and is 0 when there is none.
- R9: A change on a source reaches `irq_out` with no clock edge in between.
- R10: During the cycle of a write the routing and `cfg_rdata` still follow the old control value. The new value applies only after the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_we | input | 1 | Write enable for the control register |
| cfg_wdata | input | 32 | Control value to be written |
| cfg_rdata | output | 32 | Current control value |
| src_b0 | input | 14 | Interrupt requests from bank 0 |
| src_b1 | input | 24 | Interrupt requests from bank 1 |
| src_b2 | input | 32 | Interrupt requests from bank 2 |
| irq_out | output | 41 | Lines 0-37 own lines, 38/39/40 shared lines of banks 0/1/2 |

## Verification
The only state in the block is the control word, and `cfg_rdata` shows it at once after any write. A wrong bit there also changes the routing: a request turns up on the wrong own line or the wrong shared line as soon as that source is driven. The sources go straight to the outputs, so a swapped pair, an inverted select or a missing OR term shows in the same cycle as the stimulus. The sweeps therefore check all 41 lines after each source pattern, under many control words, and need no waiting.

// File: rtl/irq_mux_pkg.sv
package irq_mux_pkg;

    localparam int NUM_BANKS = 3;

    // Offset of each bank's shared line above the block of own lines
    typedef enum int {
        SH_BANK0 = 0,
        SH_BANK1 = 1,
        SH_BANK2 = 2
    } shared_idx_e;

endpackage

// File: rtl/irq_mux_cfg_reg.sv
module irq_mux_cfg_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl
);

    typedef struct packed {
        logic [W-1:0] ctrl;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ctrl = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = st_q.ctrl;

endmodule

// File: rtl/irq_mux_pair_route.sv
// One select bit per pin pair: 0 gives the own line to the low-bank pin,
// 1 gives it to the bank-2 pin; the loser is passed to its shared OR.
module irq_mux_pair_route #(
    parameter int PAIRS = 14
) (
    input  logic [PAIRS-1:0] sel,
    input  logic [PAIRS-1:0] lo_src,
    input  logic [PAIRS-1:0] hi_src,
    output logic [PAIRS-1:0] own_line,
    output logic [PAIRS-1:0] lo_shared,
    output logic [PAIRS-1:0] hi_shared
);

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign own_line[p]  = sel[p] ? hi_src[p] : lo_src[p];
        assign lo_shared[p] = lo_src[p] & sel[p];
        assign hi_shared[p] = hi_src[p] & ~sel[p];
    end

endmodule

// File: rtl/irq_mux_shared_or.sv
module irq_mux_shared_or #(
    parameter int W = 14
) (
    input  logic [W-1:0] req,
    output logic         any_req
);

    assign any_req = |req;

endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux #(
    parameter int B0_W = 14,
    parameter int B1_W = 24,
    parameter int B2_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [B2_W-1:0]            cfg_wdata,
    output logic [B2_W-1:0]            cfg_rdata,
    input  logic [B0_W-1:0]            src_b0,
    input  logic [B1_W-1:0]            src_b1,
    input  logic [B2_W-1:0]            src_b2,
    output logic [B2_W+(B1_W-(B2_W-B0_W))+irq_mux_pkg::NUM_BANKS-1:0] irq_out
);

    import irq_mux_pkg::*;

    localparam int PAIR1_N  = B2_W - B0_W;
    localparam int SPARE1_N = B1_W - PAIR1_N;
    localparam int OWN_N    = B2_W + SPARE1_N;
    localparam int OUT_N    = OWN_N + NUM_BANKS;

    logic [B2_W-1:0]    ctrl;
    logic [B0_W-1:0]    own0, sh_b0, sh_b2_lo;
    logic [PAIR1_N-1:0] own1, sh_b1, sh_b2_hi;
    logic               any_b0, any_b1, any_b2;

    irq_mux_cfg_reg #(.W(B2_W)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctrl  (ctrl)
    );

    irq_mux_pair_route #(.PAIRS(B0_W)) i_route_b0 (
        .sel       (ctrl[B0_W-1:0]),
        .lo_src    (src_b0),
        .hi_src    (src_b2[B0_W-1:0]),
        .own_line  (own0),
        .lo_shared (sh_b0),
        .hi_shared (sh_b2_lo)
    );

    irq_mux_pair_route #(.PAIRS(PAIR1_N)) i_route_b1 (
        .sel       (ctrl[B2_W-1:B0_W]),
        .lo_src    (src_b1[PAIR1_N-1:0]),
        .hi_src    (src_b2[B2_W-1:B0_W]),
        .own_line  (own1),
        .lo_shared (sh_b1),
        .hi_shared (sh_b2_hi)
    );

    irq_mux_shared_or #(.W(B0_W)) i_or_b0 (
        .req     (sh_b0),
        .any_req (any_b0)
    );

    irq_mux_shared_or #(.W(PAIR1_N)) i_or_b1 (
        .req     (sh_b1),
        .any_req (any_b1)
    );

    irq_mux_shared_or #(.W(B2_W)) i_or_b2 (
        .req     ({sh_b2_hi, sh_b2_lo}),
        .any_req (any_b2)
    );

    assign irq_out[B0_W-1:0]    = own0;
    assign irq_out[B2_W-1:B0_W] = own1;

    if (SPARE1_N > 0) begin : g_spare
        assign irq_out[OWN_N-1:B2_W] = src_b1[B1_W-1:PAIR1_N];
    end

    assign irq_out[OWN_N + int'(SH_BANK0)] = any_b0;
    assign irq_out[OWN_N + int'(SH_BANK1)] = any_b1;
    assign irq_out[OUT_N - 1]              = any_b2;

    assign cfg_rdata = ctrl;

endmodule

// File: rtl/irq_mux_checker.sv
module irq_mux_checker #(
    parameter int B0_W = 14,
    parameter int B1_W = 24,
    parameter int B2_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_we,
    input logic [B2_W-1:0]            cfg_wdata,
    input logic [B2_W-1:0]            cfg_rdata,
    input logic [B0_W-1:0]            src_b0,
    input logic [B1_W-1:0]            src_b1,
    input logic [B2_W-1:0]            src_b2,
    input logic [B2_W+(B1_W-(B2_W-B0_W))+3-1:0] irq_out
);

    localparam int PAIR1_N = B2_W - B0_W;
    localparam int OWN_N   = B2_W + (B1_W - PAIR1_N);

    logic [B2_W-1:0] c_all;
    assign c_all = cfg_rdata;

    // R1: reset leaves a cleared control word
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> cfg_rdata == '0);

    // R2: a write is visible on the following cycle
    p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata));

    // R2: no write, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    // R3: pairs of bank 0 and bank 2
    p_pair_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[B0_W-1:0] ==
            ((src_b2[B0_W-1:0] & c_all[B0_W-1:0]) | (src_b0 & ~c_all[B0_W-1:0])));

    // R4: pairs of bank 1 and bank 2
    p_pair_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[B2_W-1:B0_W] ==
            ((src_b2[B2_W-1:B0_W] & c_all[B2_W-1:B0_W]) |
             (src_b1[PAIR1_N-1:0] & ~c_all[B2_W-1:B0_W])));

    // R5: unpaired bank 1 pins
    p_fixed_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[OWN_N-1:B2_W] == src_b1[B1_W-1:PAIR1_N]);

    // R6
    p_shared_b0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[OWN_N] == ((src_b0 & c_all[B0_W-1:0]) != '0));

    // R7
    p_shared_b1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[OWN_N+1] == ((src_b1[PAIR1_N-1:0] & c_all[B2_W-1:B0_W]) != '0));

    // R8
    p_shared_b2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[OWN_N+2] == ((src_b2 & ~c_all) != '0));

endmodule

bind irq_line_mux irq_mux_checker #(
    .B0_W (B0_W),
    .B1_W (B1_W),
    .B2_W (B2_W)
) i_irq_mux_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .src_b0    (src_b0),
    .src_b1    (src_b1),
    .src_b2    (src_b2),
    .irq_out   (irq_out)
);

// File: tb/test_irq_line_mux.sv
`timescale 1ns/1ps
module test_irq_line_mux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [13:0] src_b0 = '0;
    logic [23:0] src_b1 = '0;
    logic [31:0] src_b2 = '0;
    logic [40:0] irq_out;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [31:0] cur_cfg = '0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    irq_line_mux i_irq_line_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .src_b0    (src_b0),
        .src_b1    (src_b1),
        .src_b2    (src_b2),
        .irq_out   (irq_out)
    );

    function automatic logic [40:0] model(input logic [31:0] c, input logic [13:0] a,
                                          input logic [23:0] b, input logic [31:0] d);
        logic [40:0] m = '0;
        for (int i = 0; i < 14; i++) begin
            m[i] = c[i] ? d[i] : a[i];
            if (c[i]) m[38] = m[38] | a[i];
            else      m[40] = m[40] | d[i];
        end
        for (int k = 0; k < 18; k++) begin
            m[14+k] = c[14+k] ? d[14+k] : b[k];
            if (c[14+k]) m[39] = m[39] | b[k];
            else         m[40] = m[40] | d[14+k];
        end
        for (int s = 0; s < 6; s++) m[32+s] = b[18+s];
        return m;
    endfunction

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] x = v;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_lines(input logic [31:0] c);
        logic [40:0] e = model(c, src_b0, src_b1, src_b2);
        chk("R3", 64'(irq_out[13:0]),  64'(e[13:0]));
        chk("R4", 64'(irq_out[31:14]), 64'(e[31:14]));
        chk("R5", 64'(irq_out[37:32]), 64'(e[37:32]));
        chk("R6", 64'(irq_out[38]),    64'(e[38]));
        chk("R7", 64'(irq_out[39]),    64'(e[39]));
        chk("R8", 64'(irq_out[40]),    64'(e[40]));
    endtask

    task automatic drive(input logic [69:0] v);
        src_b0 = v[13:0];
        src_b1 = v[37:14];
        src_b2 = v[69:38];
        #1;
        check_lines(cur_cfg);
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        #1;
        // R10: still old value within the write cycle
        chk("R10", 64'(cfg_rdata), 64'(cur_cfg));
        check_lines(cur_cfg);
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = ~v;
        cur_cfg = v;
        #1;
        chk("R2", 64'(cfg_rdata), 64'(v));
        check_lines(cur_cfg);
    endtask

    task automatic sweep_sources();
        drive('0);
        drive('1);
        for (int b = 0; b < 70; b++) drive(70'(1) << b);
        for (int r = 0; r < 8; r++) begin
            rng = xs(rng);
            drive({rng[5:0], xs(rng), rng});
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a write attempted during reset
        cfg_we = 1'b1;
        cfg_wdata = 32'hFFFF_FFFF;
        src_b0 = 14'h2AAA;
        src_b1 = 24'h5A5A5A;
        src_b2 = 32'hC3C3_C3C3;
        repeat (3) @(negedge clk);
        chk("R1", 64'(cfg_rdata), 64'h0);
        check_lines(32'h0);
        cfg_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 64'(cfg_rdata), 64'h0);
        check_lines(32'h0);

        // R2: idle cycles keep the value
        write_cfg(32'h9E37_79B9);
        repeat (2) @(negedge clk);
        chk("R2", 64'(cfg_rdata), 64'h9E37_79B9);

        // R9: source change between edges seen without a clock edge
        @(posedge clk);
        #5;
        src_b0 = '0; src_b1 = '0; src_b2 = '0;
        #1;
        check_lines(cur_cfg);
        src_b2[0] = 1'b1;
        #1;
        chk("R9", 64'(irq_out[0]), 64'(cur_cfg[0]));
        chk("R9", 64'(irq_out[40]), 64'(!cur_cfg[0]));

        // Control word sweep
        write_cfg(32'h0);          sweep_sources();
        write_cfg(32'hFFFF_FFFF);  sweep_sources();
        write_cfg(32'h5555_5555);  sweep_sources();
        write_cfg(32'hAAAA_AAAA);  sweep_sources();
        for (int j = 0; j < 32; j++) begin
            write_cfg(32'(1) << j);
            sweep_sources();
        end
        for (int j = 0; j < 12; j++) begin
            rng = xs(rng);
            write_cfg(rng);
            sweep_sources();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule